// File: doc/BRIEF.md
# Critical-Quad-First Line Burst Address Sequencer

This block produces the address sequence for moving one cache line over a bus that carries one quad (8 bytes) per beat. A line is 32 bytes, so a fill or drain takes four beats. The requester supplies the byte address that missed. The first beat carries the quad that contains that byte, so the waiting access can finish as early as possible. The remaining three quads follow in toggle order: the quad index on beat k is the critical quad index XOR k. This order is not a linear wrap. A request at offset 0x10 gives 0x10, 0x18, 0x00, 0x08.

A start request is taken only while the sequencer is idle. It then presents one aligned quad address per beat and moves to the next beat only when the bus accepts the current one. It marks the final beat. One cycle after that beat is accepted, it raises a single-cycle completion pulse. The sequencer handles addresses and beat counting only. Data, arbitration and line storage belong to the surrounding logic.

Top module: `quadBurstSeq`

## Requirements
- R1: After a synchronous reset, beatValid, beatLast and burstDone are all low.
- R2: When startValid is high while idle, beatValid goes high on the next cycle. The first beatAddr is then the quad that holds the requested byte: the start address with bits [2:0] cleared.
- R3: On beat k (k = 0..3), beatAddr keeps bits [ADDR_W-1:5] of the start address. Bits [4:3] equal start bits [4:3] XOR k, and bits [2:0] are zero. The resulting orders are:
  - a start in 0x00-0x07 gives 0x00, 0x08, 0x10, 0x18;
  - a start in 0x08-0x0F gives 0x08, 0x00, 0x18, 0x10;
  - a start in 0x10-0x17 gives 0x10, 0x18, 0x00, 0x08;
  - a start in 0x18-0x1F gives 0x18, 0x10, 0x08, 0x00.
- R4: The sequencer advances a beat only on a cycle where beatValid and beatReady are both high. While beatReady is low, beatValid and beatAddr hold.
- R5: beatLast is high exactly while the fourth beat is presented.
- R6: In the cycle after the fourth beat is accepted, burstDone is high for one cycle and beatValid is low.
- R7: A startValid that arrives while a burst is active has no effect. The burst continues with the addresses of the original request.
- R8: A start presented in the cycle that burstDone is high is accepted, so bursts can run back to back.
- R9: A reset asserted during a burst returns the sequencer to idle, with no beat valid, on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startValid | input | 1 | Start request with a missed byte address |
| startAddr | input | ADDR_W | Byte address of the missed access |
| beatReady | input | 1 | Bus accepts the current beat |
| beatValid | output | 1 | A beat address is presented |
| beatAddr | output | ADDR_W | Aligned quad address of the current beat |
| beatLast | output | 1 | Current beat is the last of the line |
| burstDone | output | 1 | One-cycle pulse after the last beat is accepted |

## Verification
The assertions check on every cycle the properties that are local in time:
- the beat and address hold while a beat is stalled;
- beatLast never appears without beatValid;
- the done pulse follows an accepted last beat and comes with beatValid low;
- an active burst does not drop before its last beat;
- each accepted beat keeps the line base and changes the quad index.

The complete four-address toggle order for each critical quad, and the rejection of a start during a burst, can only be shown by the bench's scenarios. The same holds for back-to-back starts on the done cycle and for reset in the middle of a burst. In these scenarios, a behavioural model predicts every beat and compares it with the design each cycle.

// File: rtl/quad_burst_pkg.sv
package quad_burst_pkg;

  // Strobes from the sequencing control to the address datapath
  typedef struct packed {
    logic load;   // capture a new start address, beat index to zero
    logic step;   // move to the next beat of the line
  } seqStrobes_t;

endpackage

// File: rtl/quadBurstPath.sv
module quadBurstPath
  import quad_burst_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              onFinal
);

  localparam int BEATS  = LINE_BYTES / BEAT_BYTES;
  localparam int OFF_W  = $clog2(BEAT_BYTES);
  localparam int IDX_W  = $clog2(BEATS);
  localparam int LINE_W = OFF_W + IDX_W;
  localparam int BASE_W = ADDR_W - LINE_W;
  localparam logic [IDX_W-1:0] FINAL_IDX = IDX_W'(BEATS - 1);

  logic [BASE_W-1:0] baseQ;
  logic [IDX_W-1:0]  critQ;
  logic [IDX_W-1:0]  beatCntQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ    <= '0;
      critQ    <= '0;
      beatCntQ <= '0;
    end else if (strobes.load) begin
      baseQ    <= startAddr[ADDR_W-1:LINE_W];
      critQ    <= startAddr[LINE_W-1:OFF_W];
      beatCntQ <= '0;
    end else if (strobes.step) begin
      beatCntQ <= beatCntQ + 1'b1;
    end
  end

  // Toggle order: the quad index is the critical index XOR the beat count
  assign beatAddr = {baseQ, critQ ^ beatCntQ, {OFF_W{1'b0}}};
  assign onFinal  = (beatCntQ == FINAL_IDX);

  // R3: an accepted beat keeps the line base
  p_base_hold_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.step |=> beatAddr[ADDR_W-1:LINE_W] == $past(beatAddr[ADDR_W-1:LINE_W]));

  // R3: an accepted beat always moves to a different quad of the line
  p_quad_moves_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.step |=> beatAddr[LINE_W-1:OFF_W] != $past(beatAddr[LINE_W-1:OFF_W]));

endmodule

// File: rtl/quadBurstCtrl.sv
module quadBurstCtrl
  import quad_burst_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startValid,
  input  logic        beatReady,
  input  logic        onFinal,
  output seqStrobes_t strobes,
  output logic        beatValid,
  output logic        beatLast,
  output logic        burstDone
);

  typedef enum logic {ST_IDLE, ST_BURST} seqState_t;

  seqState_t stateQ;
  logic      doneQ;
  logic      acceptBeat;
  logic      finishBurst;

  assign acceptBeat  = (stateQ == ST_BURST) && beatReady;
  assign finishBurst = acceptBeat && onFinal;

  always_comb begin
    strobes      = '0;
    strobes.load = (stateQ == ST_IDLE) && startValid;
    strobes.step = acceptBeat && !onFinal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= finishBurst;
      case (stateQ)
        ST_IDLE:  if (startValid) stateQ <= ST_BURST;
        ST_BURST: if (finishBurst) stateQ <= ST_IDLE;
        default:  stateQ <= ST_IDLE;
      endcase
    end
  end

  assign beatValid = (stateQ == ST_BURST);
  assign beatLast  = (stateQ == ST_BURST) && onFinal;
  assign burstDone = doneQ;

  // R5: the final-beat flag only accompanies a presented beat
  p_last_valid_r5: assert property (@(posedge clk) disable iff (rst)
    beatLast |-> beatValid);

  // R6: the done pulse follows an accepted final beat, with the bus idle
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    burstDone |-> !beatValid && $past(beatLast && beatReady));

  // R7: an active burst cannot end before its final beat is accepted
  p_burst_holds_r7: assert property (@(posedge clk) disable iff (rst)
    beatValid && !(beatReady && beatLast) |=> beatValid && !burstDone);

endmodule

// File: rtl/quadBurstSeq.sv
module quadBurstSeq
  import quad_burst_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              beatReady,
  output logic              beatValid,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              beatLast,
  output logic              burstDone
);

  seqStrobes_t strobes;
  logic        onFinal;

  quadBurstCtrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startValid (startValid),
    .beatReady  (beatReady),
    .onFinal    (onFinal),
    .strobes    (strobes),
    .beatValid  (beatValid),
    .beatLast   (beatLast),
    .burstDone  (burstDone)
  );

  quadBurstPath #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .BEAT_BYTES (BEAT_BYTES)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .startAddr (startAddr),
    .beatAddr  (beatAddr),
    .onFinal   (onFinal)
  );

  // R4: a stalled beat holds its address and stays valid
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    beatValid && !beatReady |=> beatValid && $stable(beatAddr));

endmodule

// File: tb/quadBurstSeq_tb.sv
module quadBurstSeq_tb;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          startValid;
  logic [AW-1:0] startAddr;
  logic          beatReady;
  logic          beatValid;
  logic [AW-1:0] beatAddr;
  logic          beatLast;
  logic          burstDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  quadBurstSeq u_dut (
    .clk(clk), .rst(rst), .startValid(startValid), .startAddr(startAddr),
    .beatReady(beatReady), .beatValid(beatValid), .beatAddr(beatAddr),
    .beatLast(beatLast), .burstDone(burstDone)
  );

  // Behavioural reference: a queue of expected beat addresses per burst
  logic [AW-1:0] mQueue[$];
  bit            mDone;

  always @(posedge clk) begin
    if (rst) begin
      mQueue.delete();
      mDone = 0;
    end else begin
      mDone = 0;
      if (mQueue.size() == 0) begin
        if (startValid) begin
          for (int k = 0; k < 4; k++) begin
            int q;
            q = ((startAddr / 8) % 4) ^ k;
            mQueue.push_back((startAddr / 32) * 32 + q * 8);
          end
        end
      end else if (beatReady) begin
        void'(mQueue.pop_front());
        if (mQueue.size() == 0) mDone = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  // Full-cycle comparison against the reference model
  task automatic compare();
    bit expValid;
    expValid = (mQueue.size() != 0);
    chk(beatValid === expValid, "R2 beatValid", AW'(beatValid), AW'(expValid));
    if (expValid) begin
      chk(beatAddr === mQueue[0], "R3 beatAddr", beatAddr, mQueue[0]);
      chk(beatLast === (mQueue.size() == 1), "R5 beatLast", AW'(beatLast),
          AW'(mQueue.size() == 1));
    end else begin
      chk(beatLast === 1'b0, "R5 beatLast idle", AW'(beatLast), '0);
    end
    chk(burstDone === mDone, "R6 burstDone", AW'(burstDone), AW'(mDone));
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
  endtask

  // Run a full burst with beatReady pattern; checks order explicitly
  task automatic burst(input logic [AW-1:0] a, input logic [AW-1:0] e0,
                       input logic [AW-1:0] e1, input logic [AW-1:0] e2,
                       input logic [AW-1:0] e3, input bit stall);
    logic [AW-1:0] exps[4];
    exps = '{e0, e1, e2, e3};
    startValid = 1; startAddr = a; beatReady = 0;
    cyc();
    startValid = 0;
    for (int k = 0; k < 4; k++) begin
      if (stall) begin
        beatReady = 0;
        cyc();
        chk(beatValid && beatAddr === exps[k], "R4 stall hold", beatAddr, exps[k]);
      end
      chk(beatAddr === exps[k], "R3 order", beatAddr, exps[k]);
      beatReady = 1;
      cyc();
    end
    beatReady = 0;
    chk(burstDone === 1'b1 && beatValid === 1'b0, "R6 done pulse", AW'(burstDone), 1);
    cyc();
    chk(burstDone === 1'b0, "R6 single pulse", AW'(burstDone), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; startValid = 0; startAddr = '0; beatReady = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    cyc();
    // R1: reset state
    chk(!beatValid && !beatLast && !burstDone, "R1 reset", AW'(beatValid), 0);

    // R2 and R3: the four critical-quad orders
    burst(32'h0000_1003, 32'h1000, 32'h1008, 32'h1010, 32'h1018, 0);
    burst(32'hABCD_E12C, 32'hABCD_E128, 32'hABCD_E120, 32'hABCD_E138, 32'hABCD_E130, 0);
    burst(32'h0000_0010, 32'h0010, 32'h0018, 32'h0000, 32'h0008, 1);
    burst(32'hFFFF_FFFF, 32'hFFFF_FFF8, 32'hFFFF_FFF0, 32'hFFFF_FFE8, 32'hFFFF_FFE0, 1);

    // R7: a start during a burst is ignored
    startValid = 1; startAddr = 32'h0000_2010; beatReady = 0;
    cyc();
    startAddr = 32'h0000_5FF8; beatReady = 1;
    cyc();
    chk(beatAddr === 32'h2018, "R7 start ignored", beatAddr, 32'h2018);
    cyc();
    chk(beatAddr === 32'h2000, "R7 start ignored", beatAddr, 32'h2000);
    startValid = 0;
    cyc();
    chk(beatLast === 1'b1, "R7 last of original", AW'(beatLast), 1);

    // R8: start presented in the done cycle is accepted
    cyc();
    chk(burstDone === 1'b1, "R8 done cycle", AW'(burstDone), 1);
    startValid = 1; startAddr = 32'h0000_3008; beatReady = 0;
    cyc();
    startValid = 0;
    chk(beatValid && beatAddr === 32'h3008, "R8 back to back", beatAddr, 32'h3008);
    beatReady = 1;
    cyc();

    // R9: reset mid burst
    rst = 1; beatReady = 0;
    cyc();
    rst = 0;
    chk(!beatValid && !beatLast && !burstDone, "R9 reset mid burst", AW'(beatValid), 0);
    cyc();
    chk(!beatValid, "R9 stays idle", AW'(beatValid), 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule